// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 128K words by 8 bits. The host presents a single-cycle request with an address, a direction flag and, for writes, a data byte. The controller sequences the memory's two select lines, read strobe and write strobe, and the direction of the shared data pins, using clock-cycle counts. These counts are derived at elaboration from nanosecond limits and the clock period. Each limit is rounded up to a whole cycle, and no phase is shorter than one cycle.

A read keeps the memory selected with the read strobe active until the slowest of the address-access, strobe-to-data and cycle-time limits has passed. It then captures the byte and returns it with a one-cycle valid pulse. After the read, a turnaround idles the bus long enough for the memory's outputs to float. A write first drops the write strobe with the pins undriven, which lets the memory's outputs float. It then drives the data for at least the data-setup time and ends the strobe, the selects and the drive together. A sleep input parks the memory deselected for supply reduction. After the input is released, the controller keeps the host waiting for a recovery interval of milliseconds.

Top module: `sram_seq_ctrl`

## Requirements
- R1: Out of reset and when idle, the memory is deselected (`mem_ce1_n`=1, `mem_ce2`=0), `mem_oe_n`=1, `mem_we_n`=1, `mem_dq_oe`=0, `req_busy`=0 and `rsp_valid`=0.
- R2: The memory counts as selected only while `mem_ce1_n`=0 and `mem_ce2`=1. Every access holds that pair for its whole strobe, and outside an access the controller leaves it deselected.
- R3: A read holds select, `mem_oe_n`=0, `mem_we_n`=1 and a constant address for RD_CYC cycles. RD_CYC is the largest of the rounded address-access, strobe-to-data and read-cycle limits. The byte present at the end of that window is returned on `rsp_rdata` with `rsp_valid` high for exactly one cycle.
- R4: During a write, `mem_we_n` stays low for at least the largest of the rounded write-pulse, select-to-end, address-to-end and write-cycle limits. `mem_oe_n` stays high and the address does not change while the strobe is low.
- R5: `mem_dq_oe` stays low for the first WHZ_CYC cycles of the write strobe. It then stays high for at least DW_CYC cycles with the write byte on `mem_dq_o`, and falls on the same edge on which `mem_we_n` rises.
- R6: `mem_dq_oe` is never high while `mem_oe_n` is low.
- R7: A read keeps `req_busy` high for RD_CYC+OHZ_CYC cycles in total, so the next access can start only after an output-disable turnaround.
- R8: An accepted request (valid, not busy, not sleeping) raises `req_busy` on the next cycle. A write keeps it high for WHZ_CYC+DRV_CYC cycles. Requests made while busy are ignored.
- R9: While `sleep_req` is high the memory stays deselected, `req_busy` is high and requests have no effect on the memory.
- R10: When `sleep_req` falls, `req_busy` stays high for REC_CYC+1 more cycles before a request can be accepted. Requests made in that interval are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Write byte |
| sleep_req | input | 1 | Hold memory deselected for supply reduction |
| req_busy | output | 1 | Sequence or sleep/recovery in progress |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 8 | Read byte |
| mem_addr | output | 17 | Memory address bus |
| mem_ce1_n | output | 1 | Low-active select |
| mem_ce2 | output | 1 | High-active select |
| mem_oe_n | output | 1 | Low-active read strobe |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_dq_o | output | 8 | Data toward the memory |
| mem_dq_i | input | 8 | Data from the memory |
| mem_dq_oe | output | 1 | Pad drive enable for the data pins |

## Verification
The bench's memory model presents junk data until the read strobe and address have been steady for the full access window. A controller that captures even one cycle early therefore returns the wrong byte. The model also measures every write strobe: its length, the address held under it, the cycles before the drive starts and the cycles the data is driven. A missing float delay, a short data setup or a drive released late each shows up as a miscompare. Busy durations are timed so that a missing read-to-write turnaround or a shortened recovery is caught. Requests made while the controller is busy, asleep or recovering are later read back to confirm they left the memory untouched.

// File: rtl/sram_seq_pkg.sv
`timescale 1ns/1ps
package sram_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD     = 3'd1,
    ST_RD_TA  = 3'd2,
    ST_WR_HZ  = 3'd3,
    ST_WR_DRV = 3'd4,
    ST_SLEEP  = 3'd5,
    ST_REC    = 3'd6
  } seq_state_e;

  // nanoseconds to cycles, rounded up, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CW'(1));

  // every phase lasts at least one cycle (R3, R4, R5)
  p_load_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0));

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_seq_pkg::*;
#(
  parameter int CW      = 8,
  parameter int RD_CYC  = 1,
  parameter int OHZ_CYC = 1,
  parameter int WHZ_CYC = 1,
  parameter int DRV_CYC = 1,
  parameter int REC_CYC = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  input  logic       sleep_req,
  output seq_state_e state_q,
  output seq_state_e state_d,
  output logic       accept,
  output logic       capture
);

  logic          t_load;
  logic [CW-1:0] t_val;
  logic          t_last;

  sram_phase_timer #(.CW(CW)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .last     (t_last)
  );

  always_comb begin
    state_d = state_q;
    t_load  = 1'b0;
    t_val   = '0;
    accept  = 1'b0;
    capture = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (sleep_req) begin
          state_d = ST_SLEEP;
        end else if (req_valid) begin
          accept = 1'b1;
          t_load = 1'b1;
          if (req_write) begin
            state_d = ST_WR_HZ;
            t_val   = CW'(WHZ_CYC);
          end else begin
            state_d = ST_RD;
            t_val   = CW'(RD_CYC);
          end
        end
      end
      ST_RD: begin
        if (t_last) begin
          capture = 1'b1;
          state_d = ST_RD_TA;
          t_load  = 1'b1;
          t_val   = CW'(OHZ_CYC);
        end
      end
      ST_RD_TA: begin
        if (t_last) state_d = ST_IDLE;
      end
      ST_WR_HZ: begin
        if (t_last) begin
          state_d = ST_WR_DRV;
          t_load  = 1'b1;
          t_val   = CW'(DRV_CYC);
        end
      end
      ST_WR_DRV: begin
        if (t_last) state_d = ST_IDLE;
      end
      ST_SLEEP: begin
        if (!sleep_req) begin
          state_d = ST_REC;
          t_load  = 1'b1;
          t_val   = CW'(REC_CYC);
        end
      end
      ST_REC: begin
        if (t_last) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // sleep holds until released
  p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP && sleep_req) |=> (state_q == ST_SLEEP));

  // capture only ends a read window
  p_capture_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (state_q == ST_RD_TA));

endmodule

// File: rtl/sram_pin_regs.sv
`timescale 1ns/1ps
module sram_pin_regs
  import sram_seq_pkg::*;
#(
  parameter int AW = 17,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  seq_state_e    state_d,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] mem_dq_i,
  output logic          req_busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce1_n,
  output logic          mem_ce2,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe
);

  logic          sel_q, sel_d;
  logic          rd_q, rd_d;
  logic          wr_q, wr_d;
  logic          drv_q, drv_d;
  logic          busy_q, busy_d;
  logic          rvld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] rdata_q;

  always_comb begin
    rd_d   = (state_d == ST_RD);
    wr_d   = (state_d == ST_WR_HZ) || (state_d == ST_WR_DRV);
    drv_d  = (state_d == ST_WR_DRV);
    sel_d  = rd_d || wr_d;
    busy_d = (state_d != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      drv_q  <= 1'b0;
      busy_q <= 1'b0;
      rvld_q <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      drv_q  <= drv_d;
      busy_q <= busy_d;
      rvld_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (capture) rdata_q <= mem_dq_i;
  end

  assign mem_ce1_n = ~sel_q;
  assign mem_ce2   = sel_q;
  assign mem_oe_n  = ~rd_q;
  assign mem_we_n  = ~wr_q;
  assign mem_dq_oe = drv_q;
  assign mem_dq_o  = wdata_q;
  assign mem_addr  = addr_q;
  assign req_busy  = busy_q;
  assign rsp_valid = rvld_q;
  assign rsp_rdata = rdata_q;

  p_no_contention_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_drive_inside_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_we_n);

  p_float_before_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_we_n) |-> !mem_dq_oe);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  p_strobes_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  p_rsp_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_strobe_needs_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> (!mem_ce1_n && mem_ce2));

endmodule

// File: rtl/sram_seq_ctrl.sv
`timescale 1ns/1ps
module sram_seq_ctrl
  import sram_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 20,
  parameter int T_RC_NS   = 15,
  parameter int T_AA_NS   = 15,
  parameter int T_OE_NS   = 9,
  parameter int T_OHZ_NS  = 9,
  parameter int T_WC_NS   = 15,
  parameter int T_WP_NS   = 10,
  parameter int T_CW_NS   = 12,
  parameter int T_AW_NS   = 12,
  parameter int T_DW_NS   = 10,
  parameter int T_WHZ_NS  = 8,
  parameter int T_REC_NS  = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sleep_req,
  output logic              req_busy,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce1_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  localparam int RD_CYC  = imax(imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OE_NS, CLK_NS)),
                                ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int OHZ_CYC = ns_to_cyc(T_OHZ_NS, CLK_NS);
  localparam int WHZ_CYC = ns_to_cyc(T_WHZ_NS, CLK_NS);
  localparam int WE_MIN  = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_CW_NS, CLK_NS)),
                                imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_WC_NS, CLK_NS)));
  localparam int DRV_CYC = imax(ns_to_cyc(T_DW_NS, CLK_NS), WE_MIN - WHZ_CYC);
  localparam int REC_CYC = ns_to_cyc(T_REC_NS, CLK_NS);
  localparam int MAX_CYC = imax(imax(imax(RD_CYC, OHZ_CYC), imax(WHZ_CYC, DRV_CYC)), REC_CYC);
  localparam int CW      = $clog2(MAX_CYC + 1);

  seq_state_e state_q;
  seq_state_e state_d;
  logic       accept;
  logic       capture;

  sram_seq_fsm #(
    .CW      (CW),
    .RD_CYC  (RD_CYC),
    .OHZ_CYC (OHZ_CYC),
    .WHZ_CYC (WHZ_CYC),
    .DRV_CYC (DRV_CYC),
    .REC_CYC (REC_CYC)
  ) fsm_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .sleep_req (sleep_req),
    .state_q   (state_q),
    .state_d   (state_d),
    .accept    (accept),
    .capture   (capture)
  );

  sram_pin_regs #(.AW(ADDR_W), .DW(DATA_W)) pins_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .mem_dq_i  (mem_dq_i),
    .req_busy  (req_busy),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .mem_addr  (mem_addr),
    .mem_ce1_n (mem_ce1_n),
    .mem_ce2   (mem_ce2),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
  );

  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_busy && req_valid && !sleep_req) |=> req_busy);

  p_sleep_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLEEP || state_q == ST_REC) |-> (mem_ce1_n && !mem_ce2));

  p_sleep_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REC) |-> req_busy);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (mem_we_n && mem_oe_n && !mem_dq_oe && !req_busy));

endmodule

// File: tb/sram_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_seq_ctrl_tb_top;

  localparam int RD_CYC  = 3;    // ceil(50/20)
  localparam int OHZ_CYC = 2;    // ceil(30/20)
  localparam int WHZ_CYC = 1;    // ceil(8/20)
  localparam int WE_MIN  = 2;    // ceil(30/20)
  localparam int DW_CYC  = 2;    // ceil(40/20)
  localparam int DRV_CYC = 2;
  localparam int REC_CYC = 100;  // 2000/20
  localparam logic [7:0] FILL = 8'h5A;
  localparam logic [7:0] JUNK = 8'hEE;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, sleep_req;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_busy, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [7:0]  mem_dq_o;
  logic [7:0]  mem_dq_i;

  always #10 clk = ~clk;

  sram_seq_ctrl #(
    .CLK_NS(20), .T_AA_NS(50), .T_OHZ_NS(30), .T_WP_NS(30),
    .T_DW_NS(40), .T_REC_NS(2000)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .sleep_req(sleep_req),
    .req_busy(req_busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_dq_o(mem_dq_o),
    .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  int n_vec = 0;
  int n_err = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
    end
  endtask

  // ---------------- memory model ----------------
  logic [7:0] model_mem [int unsigned];
  logic       prev_we_n = 1'b1;
  int         we_len, drv_len, rd_age;
  bit         addr_ok, oe_ok;
  logic [16:0] w_addr, rd_addr;
  logic [7:0]  w_data;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_we_n = 1'b1;
      rd_age    = 0;
      mem_dq_i <= JUNK;
    end else begin
      if (mem_dq_oe) chk(mem_oe_n, "R6 drive while read strobe", 0, 1);
      if (!mem_we_n) begin
        if (prev_we_n) begin
          we_len = 1; drv_len = 0; addr_ok = 1'b1; oe_ok = 1'b1; w_addr = mem_addr;
        end else begin
          we_len++;
          if (mem_addr != w_addr) addr_ok = 1'b0;
        end
        if (!mem_oe_n || mem_ce1_n || !mem_ce2) oe_ok = 1'b0;
        if (mem_dq_oe) begin
          chk(we_len > WHZ_CYC, "R5 drive before float", we_len, WHZ_CYC + 1);
          drv_len++;
          w_data = mem_dq_o;
        end
      end else if (!prev_we_n) begin
        chk(we_len >= WE_MIN, "R4 strobe length", we_len, WE_MIN);
        chk(addr_ok, "R4 address moved under strobe", 0, 1);
        chk(oe_ok, "R2/R4 select or read strobe during write", 0, 1);
        chk(drv_len >= DW_CYC, "R5 data setup", drv_len, DW_CYC);
        chk(!mem_dq_oe, "R5 drive after strobe", 1, 0);
        model_mem[w_addr] = w_data;
      end
      prev_we_n = mem_we_n;
      if (!mem_ce1_n && mem_ce2 && !mem_oe_n && mem_we_n) begin
        if (rd_age > 0 && mem_addr == rd_addr) rd_age++;
        else begin rd_age = 1; rd_addr = mem_addr; end
      end else rd_age = 0;
      if (rd_age >= RD_CYC)
        mem_dq_i <= model_mem.exists(rd_addr) ? model_mem[rd_addr] : FILL;
      else
        mem_dq_i <= JUNK;
    end
  end

  // ---------------- scoreboard ----------------
  logic [7:0] exp_q [$];
  logic [7:0] shadow [int unsigned];
  logic       prev_rv = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        chk(!prev_rv, "R3 valid pulse width", 2, 1);
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected response", rsp_rdata, 0);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(rsp_rdata == e, "R3 read data", rsp_rdata, e);
        end
      end
      prev_rv = rsp_valid;
    end
  end

  // ---------------- driver ----------------
  task automatic wait_idle();
    while (req_busy) @(negedge clk);
  endtask

  task automatic issue(input bit wr, input logic [16:0] a, input logic [7:0] d,
                       input bit stray = 1'b0);
    int n;
    wait_idle();
    if (wr) shadow[a] = d;
    else    exp_q.push_back(shadow.exists(a) ? shadow[a] : FILL);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    chk(req_busy, "R8 busy after accept", req_busy, 1);
    if (stray) begin
      req_write = 1'b1; req_addr = a; req_wdata = ~d;  // ignored while busy
    end else req_valid = 1'b0;
    n = 0;
    while (req_busy) begin
      n++;
      @(negedge clk);
      req_valid = 1'b0;
    end
    if (wr) chk(n == WHZ_CYC + DRV_CYC, "R8 write busy length", n, WHZ_CYC + DRV_CYC);
    else    chk(n == RD_CYC + OHZ_CYC, "R7 read busy length", n, RD_CYC + OHZ_CYC);
  endtask

  initial begin
    #(200000 * 20);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; sleep_req = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_ce1_n && !mem_ce2, "R1 deselected", {mem_ce1_n, mem_ce2}, 2'b10);
    chk(mem_oe_n && mem_we_n, "R1 strobes idle", {mem_oe_n, mem_we_n}, 2'b11);
    chk(!mem_dq_oe, "R1 no drive", mem_dq_oe, 0);
    chk(!req_busy && !rsp_valid, "R1 not busy", {req_busy, rsp_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(mem_ce1_n && !mem_ce2 && !req_busy, "R1 idle after reset", req_busy, 0);

    issue(1, 17'h00000, 8'hA5);
    issue(1, 17'h1FFFF, 8'h3C);
    issue(1, 17'h12345, 8'h81);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    issue(1, 17'h0AAAA, 8'h00);   // read-to-write turnaround path
    issue(0, 17'h12345, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    issue(0, 17'h00100, 8'h00);   // never written
    issue(1, 17'h12345, 8'h7E);   // overwrite
    issue(0, 17'h12345, 8'h00);
    issue(1, 17'h00777, 8'h11, 1'b1);  // stray request while busy
    issue(0, 17'h00777, 8'h00);        // R8: must still read 11

    // R9 sleep
    wait_idle();
    sleep_req = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00200; req_wdata = 8'h77;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(req_busy, "R9 busy while asleep", req_busy, 1);
      chk(mem_ce1_n && !mem_ce2 && mem_we_n, "R9 deselected while asleep",
          {mem_ce1_n, mem_ce2, mem_we_n}, 3'b101);
    end
    sleep_req = 1'b0;
    req_addr = 17'h00201;
    begin
      int n;
      n = 0;
      do begin
        @(negedge clk);
        n++;
        if (req_busy && !mem_ce1_n) chk(1'b0, "R10 access during recovery", 1, 0);
        if (n == REC_CYC) req_valid = 1'b0;
      end while (req_busy && n < 3 * REC_CYC);
      chk(n == REC_CYC + 1, "R10 recovery length", n, REC_CYC + 1);
    end
    req_valid = 1'b0;
    issue(0, 17'h00200, 8'h00);   // untouched by sleep-time request
    issue(0, 17'h00201, 8'h00);   // untouched by recovery-time request
    issue(0, 17'h00000, 8'h00);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R3 responses outstanding", exp_q.size(), 0);
    finish_run();
  end

endmodule